// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a small boundary-scan device. It is clocked by the test clock and follows the standard sixteen-state controller, steered by the mode-select input sampled on each rising test-clock edge. It holds an 8-bit instruction shift register, an instruction latch, a one-stage bypass register and an instruction decoder. The decoder tells the external boundary-scan chain whether it sits in the serial path and whether the system pins are driven from the chain, forced to high impedance, or left in normal operation.

The boundary-scan cells live outside this block. They take the capture, shift and update strobes from here and return their serial output on `bsr_so`. There is no identification register. Reading the instruction register therefore returns a fixed 8-bit pattern, which serves as a signature for the device. A reset, or five rising edges with mode-select held high, restores the bypass instruction.

Top module: `tap_port`

## Requirements
- R1: The controller follows the standard 16-state transition graph on each rising `tck` edge. Five consecutive rising edges with `tms` = 1 reach Test-Logic-Reset from any state, including Shift-DR.
- R2: While `rst` is high on a rising edge, the controller goes to Test-Logic-Reset. In Test-Logic-Reset the instruction latch loads 8'hFF (bypass) at the next falling edge, so `bsr_sel`, `pins_drive` and `pins_hiz` are all 0.
- R3: Capture-IR loads 8'b00111101 into the instruction shift register. In Shift-IR it leaves on `tdo` bit 0 first, so the first eight `tdo` values read 1,0,1,1,1,1,0,0.
- R4: Instruction bits enter from `tdi` least significant bit first. The instruction latch, and with it the decoded outputs, changes only at the falling edge while in Update-IR. It is unchanged in Exit1-IR after new bits have been shifted in.
- R5: Code 8'h00 (external test) gives `bsr_sel` = 1, `pins_drive` = 1, `pins_hiz` = 0.
- R6: Code 8'h81 (sample/preload) gives `bsr_sel` = 1, `pins_drive` = 0, `pins_hiz` = 0.
- R7: Code 8'h82 (clamp) gives `bsr_sel` = 0, `pins_drive` = 1, `pins_hiz` = 0. The bypass stage is in the serial path.
- R8: Code 8'h03 (high impedance) gives `bsr_sel` = 0, `pins_drive` = 0, `pins_hiz` = 1. The bypass stage is in the serial path.
- R9: Every other 8-bit code selects bypass: all three mode outputs are 0.
- R10: The bypass stage captures 0 in Capture-DR. In Shift-DR with `bsr_sel` = 0, `tdo` repeats `tdi` one `tck` period later.
- R11: `tdo_en` is 1 only in Shift-IR and Shift-DR, and `tdo` and `tdo_en` change on falling `tck` edges. In Shift-DR with `bsr_sel` = 1, `tdo` carries `bsr_so` as sampled at that falling edge.
- R12: `capture_dr`, `shift_dr` and `update_dr` are 1 exactly while the controller is in Capture-DR, Shift-DR and Update-DR respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| bsr_so | input | 1 | Serial output returned by the external boundary-scan chain |
| tdo | output | 1 | Serial data out, valid when `tdo_en` is 1 |
| tdo_en | output | 1 | Output enable for `tdo` |
| capture_dr | output | 1 | Data-register capture strobe |
| shift_dr | output | 1 | Data-register shift strobe |
| update_dr | output | 1 | Data-register update strobe (chain updates on falling `tck`) |
| bsr_sel | output | 1 | Boundary-scan chain is in the serial path |
| pins_drive | output | 1 | System outputs are driven from the chain |
| pins_hiz | output | 1 | System outputs are forced to high impedance |

## Verification
The strobes follow the controller state, so each one is valid for the whole `tck` period after the rising edge that enters its state. `tdo`, `tdo_en` and the mode outputs move half a period later, at the falling edge. The bench changes `tms` and `tdi` 2 ns after a falling edge and then waits through one rising and one falling edge before it samples anything. Every result is therefore read after the register that produces it has settled, and well before the next rising edge. All 256 instruction codes are loaded in turn. Each load also checks the captured signature and that the mode outputs hold in Exit1-IR.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    TAP_RESET  = 4'd0,
    TAP_IDLE   = 4'd1,
    TAP_SEL_DR = 4'd2,
    TAP_CAP_DR = 4'd3,
    TAP_SH_DR  = 4'd4,
    TAP_EX1_DR = 4'd5,
    TAP_PAU_DR = 4'd6,
    TAP_EX2_DR = 4'd7,
    TAP_UPD_DR = 4'd8,
    TAP_SEL_IR = 4'd9,
    TAP_CAP_IR = 4'd10,
    TAP_SH_IR  = 4'd11,
    TAP_EX1_IR = 4'd12,
    TAP_PAU_IR = 4'd13,
    TAP_EX2_IR = 4'd14,
    TAP_UPD_IR = 4'd15
  } tap_state_t;

  function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
    case (s)
      TAP_RESET:  tap_next = m ? TAP_RESET  : TAP_IDLE;
      TAP_IDLE:   tap_next = m ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_DR: tap_next = m ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR: tap_next = m ? TAP_EX1_DR : TAP_SH_DR;
      TAP_SH_DR:  tap_next = m ? TAP_EX1_DR : TAP_SH_DR;
      TAP_EX1_DR: tap_next = m ? TAP_UPD_DR : TAP_PAU_DR;
      TAP_PAU_DR: tap_next = m ? TAP_EX2_DR : TAP_PAU_DR;
      TAP_EX2_DR: tap_next = m ? TAP_UPD_DR : TAP_SH_DR;
      TAP_UPD_DR: tap_next = m ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_IR: tap_next = m ? TAP_RESET  : TAP_CAP_IR;
      TAP_CAP_IR: tap_next = m ? TAP_EX1_IR : TAP_SH_IR;
      TAP_SH_IR:  tap_next = m ? TAP_EX1_IR : TAP_SH_IR;
      TAP_EX1_IR: tap_next = m ? TAP_UPD_IR : TAP_PAU_IR;
      TAP_PAU_IR: tap_next = m ? TAP_EX2_IR : TAP_PAU_IR;
      TAP_EX2_IR: tap_next = m ? TAP_UPD_IR : TAP_SH_IR;
      TAP_UPD_IR: tap_next = m ? TAP_SEL_DR : TAP_IDLE;
      default:    tap_next = TAP_RESET;
    endcase
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t st
);

  always_ff @(posedge tck) begin
    if (rst) st <= TAP_RESET;
    else     st <= tap_next(st, tms);
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter int              IR_W     = 8,
  parameter logic [IR_W-1:0] CAP_PAT  = 8'b00111101,
  parameter logic [IR_W-1:0] RST_CODE = '1
) (
  input  logic            tck,
  input  logic            rst,
  input  logic            tdi,
  input  tap_state_t      st,
  output logic            sr_lsb,
  output logic [IR_W-1:0] ir_q
);

  logic [IR_W-1:0] sr;

  // shift stage works on the rising edge
  always_ff @(posedge tck) begin
    if (rst) begin
      sr <= CAP_PAT;
    end else if (st == TAP_CAP_IR) begin
      sr <= CAP_PAT;
    end else if (st == TAP_SH_IR) begin
      sr <= {tdi, sr[IR_W-1:1]};
    end
  end

  // instruction latch changes only on the falling edge
  always_ff @(negedge tck) begin
    if (rst || st == TAP_RESET) begin
      ir_q <= RST_CODE;
    end else if (st == TAP_UPD_IR) begin
      ir_q <= sr;
    end
  end

  assign sr_lsb = sr[0];

endmodule

// File: rtl/tap_decode.sv
module tap_decode #(
  parameter int              IR_W     = 8,
  parameter logic [IR_W-1:0] OP_EXT   = 8'h00,
  parameter logic [IR_W-1:0] OP_SMP   = 8'h81,
  parameter logic [IR_W-1:0] OP_CLAMP = 8'h82,
  parameter logic [IR_W-1:0] OP_HIZ   = 8'h03
) (
  input  logic [IR_W-1:0] ir_q,
  output logic            bsr_sel,
  output logic            pins_drive,
  output logic            pins_hiz
);

  logic hit_ext, hit_smp, hit_clamp, hit_hiz;

  always_comb begin
    hit_ext    = (ir_q == OP_EXT);
    hit_smp    = (ir_q == OP_SMP);
    hit_clamp  = (ir_q == OP_CLAMP);
    hit_hiz    = (ir_q == OP_HIZ);
    bsr_sel    = hit_ext | hit_smp;
    pins_drive = hit_ext | hit_clamp;
    pins_hiz   = hit_hiz;
  end

endmodule

// File: rtl/tap_port.sv
module tap_port
  import tap_pkg::*;
#(
  parameter int              IR_W     = 8,
  parameter logic [IR_W-1:0] CAP_PAT  = 8'b00111101,
  parameter logic [IR_W-1:0] OP_EXT   = 8'h00,
  parameter logic [IR_W-1:0] OP_SMP   = 8'h81,
  parameter logic [IR_W-1:0] OP_CLAMP = 8'h82,
  parameter logic [IR_W-1:0] OP_HIZ   = 8'h03
) (
  input  logic tck,
  input  logic rst,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_so,
  output logic tdo,
  output logic tdo_en,
  output logic capture_dr,
  output logic shift_dr,
  output logic update_dr,
  output logic bsr_sel,
  output logic pins_drive,
  output logic pins_hiz
);

  localparam logic [IR_W-1:0] RST_CODE = {IR_W{1'b1}};

  tap_state_t      st;
  logic            ir_lsb;
  logic [IR_W-1:0] ir_q;
  logic            byp_q;

  tap_fsm u_fsm (.tck(tck), .rst(rst), .tms(tms), .st(st));

  tap_ir #(.IR_W(IR_W), .CAP_PAT(CAP_PAT), .RST_CODE(RST_CODE)) u_ir (
    .tck(tck), .rst(rst), .tdi(tdi), .st(st), .sr_lsb(ir_lsb), .ir_q(ir_q)
  );

  tap_decode #(.IR_W(IR_W), .OP_EXT(OP_EXT), .OP_SMP(OP_SMP),
               .OP_CLAMP(OP_CLAMP), .OP_HIZ(OP_HIZ)) u_dec (
    .ir_q(ir_q), .bsr_sel(bsr_sel), .pins_drive(pins_drive), .pins_hiz(pins_hiz)
  );

  // single bypass stage
  always_ff @(posedge tck) begin
    if (rst)                    byp_q <= 1'b0;
    else if (st == TAP_CAP_DR)  byp_q <= 1'b0;
    else if (st == TAP_SH_DR)   byp_q <= tdi;
  end

  // serial output retimed to the falling edge
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (st == TAP_SH_IR) || (st == TAP_SH_DR);
      if (st == TAP_SH_IR)      tdo <= ir_lsb;
      else if (st == TAP_SH_DR) tdo <= bsr_sel ? bsr_so : byp_q;
      else                      tdo <= 1'b0;
    end
  end

  assign capture_dr = (st == TAP_CAP_DR);
  assign shift_dr   = (st == TAP_SH_DR);
  assign update_dr  = (st == TAP_UPD_DR);

endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
  import tap_pkg::*;
#(
  parameter int IR_W = 8
) (
  input logic            tck,
  input logic            rst,
  input tap_state_t      st,
  input logic [IR_W-1:0] ir_q,
  input logic            byp_q,
  input logic            tdo_en
);

  AST_LATCH_HOLDS: assert property (@(negedge tck) disable iff (rst)
    (st != TAP_UPD_IR && st != TAP_RESET) |=> $stable(ir_q)); // R4

  AST_RESET_BYPASS: assert property (@(posedge tck) disable iff (rst)
    (st == TAP_RESET) |-> (ir_q == {IR_W{1'b1}})); // R2

  AST_TDOEN_ONLY_SHIFT: assert property (@(posedge tck) disable iff (rst)
    tdo_en |-> (st == TAP_SH_IR || st == TAP_SH_DR)); // R11

  AST_TDOEN_IN_SHDR: assert property (@(posedge tck) disable iff (rst)
    (st == TAP_SH_DR) |-> tdo_en); // R11

  AST_BYPASS_ZERO: assert property (@(posedge tck) disable iff (rst)
    (st == TAP_CAP_DR) |=> !byp_q); // R10

endmodule

bind tap_port tap_port_chk #(.IR_W(IR_W)) u_chk (
  .tck(tck), .rst(rst), .st(st), .ir_q(ir_q), .byp_q(byp_q), .tdo_en(tdo_en)
);

// File: tb/sim_tap_port.sv
`timescale 1ns/1ps
module sim_tap_port;

  logic tck = 1'b0;
  logic rst, tms, tdi, bsr_so;
  logic tdo, tdo_en, capture_dr, shift_dr, update_dr, bsr_sel, pins_drive, pins_hiz;
  int   total = 0;
  int   bad   = 0;

  always #10 tck = ~tck;

  tap_port u0 (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
    .tdo(tdo), .tdo_en(tdo_en), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .bsr_sel(bsr_sel), .pins_drive(pins_drive), .pins_hiz(pins_hiz)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one full tck period: inputs used at the rising edge, sampled after the falling edge
  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #2;
  endtask

  // expected {bsr_sel, pins_drive, pins_hiz} per opcode
  function automatic logic [2:0] mode_of(input logic [7:0] c);
    case (c)
      8'h00:   mode_of = 3'b110;
      8'h81:   mode_of = 3'b100;
      8'h82:   mode_of = 3'b010;
      8'h03:   mode_of = 3'b001;
      default: mode_of = 3'b000;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] c);
    case (c)
      8'h00:   req_of = "R5";
      8'h81:   req_of = "R6";
      8'h82:   req_of = "R7";
      8'h03:   req_of = "R8";
      default: req_of = "R9";
    endcase
  endfunction

  logic [7:0] cur_code;

  // from Run-Test/Idle, load a code and return to Run-Test/Idle
  task automatic load_ir(input logic [7:0] code);
    logic [7:0] cap;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R11 tdo_en in Shift-IR", tdo_en, 1);
    cap[0] = tdo;
    for (int i = 0; i < 8; i++) begin
      tick(i == 7, code[i]);
      if (i < 7) cap[i+1] = tdo;
    end
    chk("R3 captured signature", cap, 8'b00111101);
    chk("R4 latch held in Exit1-IR", {bsr_sel, pins_drive, pins_hiz}, mode_of(cur_code));
    tick(1, 0);
    cur_code = code;
    chk(req_of(code), {bsr_sel, pins_drive, pins_hiz}, mode_of(code));
    tick(0, 0);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; tms = 1; tdi = 0; bsr_so = 0;
    @(negedge tck); #2;
    tick(1, 0); tick(1, 0); tick(1, 0);
    rst = 0;
    // reset state
    chk("R2 reset modes", {bsr_sel, pins_drive, pins_hiz}, 3'b000);
    chk("R11 tdo_en off after reset", tdo_en, 0);
    cur_code = 8'hFF;
    tick(0, 0);
    chk("R11 tdo_en off in Idle", tdo_en, 0);

    // sweep every opcode
    for (int c = 0; c < 256; c++) load_ir(8'(c));

    // bypass path under clamp
    load_ir(8'h82);
    tick(1, 0);
    tick(0, 0);
    chk("R12 capture_dr", {capture_dr, shift_dr, update_dr}, 3'b100);
    tick(0, 1);
    chk("R12 shift_dr", {capture_dr, shift_dr, update_dr}, 3'b010);
    chk("R10 bypass captures 0", tdo, 0);
    begin
      logic [7:0] pat = 8'b1011_0010;
      for (int i = 0; i < 8; i++) begin
        tick(0, pat[i]);
        chk("R10 bypass delay", tdo, pat[i]);
      end
    end
    // pause and resume inside the DR path
    tick(1, 0);
    chk("R11 tdo_en off in Exit1-DR", tdo_en, 0);
    tick(0, 0);
    tick(1, 0);
    tick(0, 1);
    chk("R1 Exit2-DR back to Shift-DR", tdo_en, 1);
    tick(1, 0);
    tick(1, 0);
    chk("R12 update_dr", {capture_dr, shift_dr, update_dr}, 3'b001);
    tick(0, 0);

    // high impedance instruction keeps bypass in path
    load_ir(8'h03);
    tick(1, 0); tick(0, 0); tick(0, 1);
    tick(0, 1);
    chk("R8 bypass in path under high-Z", tdo, 1);
    tick(1, 0); tick(1, 0); tick(0, 0);

    // chain in path under external test
    load_ir(8'h00);
    tick(1, 0); tick(0, 0); tick(0, 0);
    begin
      logic [5:0] sp = 6'b100110;
      for (int i = 0; i < 6; i++) begin
        bsr_so = sp[i];
        tick(0, ~sp[i]);
        chk("R11 tdo follows chain", tdo, sp[i]);
      end
    end
    // five tms-high edges from Shift-DR
    tick(1, 0); tick(1, 0); tick(1, 0); tick(1, 0);
    chk("R1 not yet reset after four", {bsr_sel, pins_drive, pins_hiz}, 3'b110);
    tick(1, 0);
    chk("R1 five tms-high reach reset", {bsr_sel, pins_drive, pins_hiz}, 3'b000);
    cur_code = 8'hFF;
    tick(0, 0);

    // synchronous reset from a test mode
    load_ir(8'h81);
    rst = 1;
    tick(0, 0);
    rst = 0;
    chk("R2 rst restores bypass", {bsr_sel, pins_drive, pins_hiz}, 3'b000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule